// File: doc/BRIEF.md
# Triggered Capture Buffer

This block is an on-chip logic analyser channel. On every clock where the sample enable is high and the block is armed, it writes one word of the monitored signal into a circular memory of 2^LGMEM words. When a trigger is seen, capture stops. The trigger sample is the newest word in the memory, so the buffer holds the history that led up to the event.

Software reads the result over a simple single-address-bit slave bus that shares the capture clock. Address 0 returns a status word. Writing to address 0 with the top data bit clear re-arms the block. Address 1 is a data port that returns the stored words one per read, from oldest to newest. The interrupt output is high for as long as capture is stopped, and it cannot be masked inside the block.

A trigger that arrives on a clock where the sample enable is low is kept. It then stops capture on the next enabled sample, so a slow enable strobe cannot hide a short trigger pulse.

Top module: `trig_capture`

## Requirements
- R1: After `rst_n` is low, or after a bus write to address 0 whose bit DW-1 is 0, the status word reads 0, `irq` is low, the buffer is empty and capture is armed.
- R2: A bus write to address 0 with bit DW-1 set has no effect. Any bus write to address 1 has no effect. After either, the status word and the data read back are unchanged.
- R3: While armed and not stopped, each clock with `smp_en` high stores `smp_data`. Clocks with `smp_en` low store nothing. The memory keeps the latest 2^LGMEM stored words.
- R4: A clock with `smp_en` and `trig_in` both high stores that sample and stops capture. From then on, the sample is the newest word read back.
- R5: If `trig_in` is high on a clock where `smp_en` is low, the status shows triggered (bit 0 = 1) but not stopped (bit 1 = 0). The next enabled sample is stored and stops capture.
- R6: The status word at address 0 holds triggered in bit 0, stopped in bit 1 and filled (2^LGMEM or more words stored since re-arm) in bit 2. All other bits are 0.
- R7: Each read of address 1 returns the next stored word and advances the readout by one, starting with the oldest. If the memory never filled, the oldest word is the first sample stored after re-arm.
- R8: `bus_ack` is high exactly on the clock after each clock with `bus_cyc` and `bus_stb` both high, and `bus_stall` is always 0.
- R9: `irq` is high exactly while capture is stopped.
- R10: A trigger or a sample that arrives while capture is stopped is ignored. It changes neither the stored data nor the state after the next re-arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared capture and bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Sample enable |
| trig_in | input | 1 | Trigger request |
| smp_data | input | DW | Monitored word |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | 1 | 0 = status/control, 1 = data port |
| bus_wdat | input | DW | Bus write data |
| bus_ack | output | 1 | Bus acknowledge |
| bus_stall | output | 1 | Bus stall, tied low |
| bus_rdat | output | DW | Bus read data |
| irq | output | 1 | Stopped indication |

## Verification
The hardest situation to reach is a stop that follows a held trigger after the memory has wrapped. In that case the oldest word sits in the middle of the memory, and the stopping sample arrives several clocks after the trigger pulse. The stimulus table uses a depth of eight. It stores ten samples, then pulses the trigger with the enable low, idles, and sends one more enabled sample, followed by a sample that must be discarded. The readout then has to start part-way around the ring and end on the late sample.

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int LGMEM = 10,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          trig_in,
  input  logic [DW-1:0] smp_data,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic          bus_adr,
  input  logic [DW-1:0] bus_wdat,
  output logic          bus_ack,
  output logic          bus_stall,
  output logic [DW-1:0] bus_rdat,
  output logic          irq
);
  localparam int DEPTH = 1 << LGMEM;

  logic [DW-1:0]    mem [DEPTH];
  logic [LGMEM-1:0] wr_ptr, rd_off;
  logic             trig_seen, stopped, filled;
  logic             ack_q;
  logic [DW-1:0]    rdat_q;

  wire bus_hit  = bus_cyc & bus_stb;
  wire soft_rst = bus_hit & bus_we & ~bus_adr & ~bus_wdat[DW-1];
  wire trig_now = trig_seen | trig_in;
  wire do_write = smp_en & ~stopped & ~soft_rst & rst_n;
  wire rd_data  = bus_hit & ~bus_we & bus_adr;

  wire [LGMEM-1:0] rd_addr = (filled ? wr_ptr : '0) + rd_off;
  wire [DW-1:0]    status  = {{(DW-3){1'b0}}, filled, stopped, trig_seen};

  always_ff @(posedge clk)
    if (do_write) mem[wr_ptr] <= smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      wr_ptr    <= '0;
      rd_off    <= '0;
      trig_seen <= 1'b0;
      stopped   <= 1'b0;
      filled    <= 1'b0;
    end else begin
      if (!stopped) begin
        if (trig_in) trig_seen <= 1'b1;
        if (smp_en) begin
          wr_ptr <= wr_ptr + 1'b1;
          if (&wr_ptr) filled <= 1'b1;
          if (trig_now) stopped <= 1'b1;
        end
      end
      if (rd_data) rd_off <= rd_off + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= bus_hit;

  always_ff @(posedge clk)
    if (bus_hit && !bus_we) rdat_q <= bus_adr ? mem[rd_addr] : status;

  assign bus_ack   = ack_q;
  assign bus_stall = 1'b0;
  assign bus_rdat  = rdat_q;
  assign irq       = stopped;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_en,
  input logic          trig_in,
  input logic          bus_cyc,
  input logic          bus_stb,
  input logic          bus_we,
  input logic          bus_adr,
  input logic [DW-1:0] bus_wdat,
  input logic          bus_ack,
  input logic          bus_stall,
  input logic          irq
);
  wire rearm = bus_cyc && bus_stb && bus_we && !bus_adr && !bus_wdat[DW-1];

  assert_stall_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall == 1'b0);
  assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb) |=> bus_ack);
  assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cyc && bus_stb) |=> !bus_ack);
  assert_rearm_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !irq);
  assert_trig_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && trig_in && !irq && !rearm) |=> irq);
  assert_no_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !irq && !rearm) |=> !irq);
  assert_stop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rearm) |=> irq);
endmodule

bind trig_capture trig_capture_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .trig_in(trig_in),
  .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
  .bus_wdat(bus_wdat), .bus_ack(bus_ack), .bus_stall(bus_stall), .irq(irq)
);

// File: tb/trig_capture_tb_top.sv
`timescale 1ns/1ps
module trig_capture_tb_top;
  localparam int LG = 3;
  localparam int DEP = 1 << LG;

  logic clk = 0;
  logic rst_n = 0;
  logic smp_en = 0, trig_in = 0;
  logic [31:0] smp_data = 0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0, bus_adr = 0;
  logic [31:0] bus_wdat = 0;
  logic bus_ack, bus_stall, irq;
  logic [31:0] bus_rdat;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] hist[$];
  bit m_hold, m_stop;

  always #4 clk = ~clk;

  trig_capture #(.LGMEM(LG), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .trig_in(trig_in),
    .smp_data(smp_data), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_ack(bus_ack),
    .bus_stall(bus_stall), .bus_rdat(bus_rdat), .irq(irq));

  // {en, trig, expected irq after, data}
  localparam logic [34:0] VEC [14] = '{
    {3'b100, 32'hA0}, {3'b100, 32'hA1}, {3'b100, 32'hA2}, {3'b100, 32'hA3},
    {3'b100, 32'hA4}, {3'b100, 32'hA5}, {3'b100, 32'hA6}, {3'b100, 32'hA7},
    {3'b100, 32'hA8}, {3'b100, 32'hA9}, {3'b010, 32'hEE}, {3'b000, 32'hEF},
    {3'b101, 32'hB0}, {3'b101, 32'hC0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    m_hold = 0;
    m_stop = 0;
  endtask

  task automatic sample(input logic [31:0] d, input bit t, input bit e);
    @(negedge clk);
    smp_en = e; trig_in = t; smp_data = d;
    if (!m_stop) begin
      if (t) m_hold = 1;
      if (e) begin
        hist.push_back(d);
        if (m_hold) m_stop = 1;
      end
    end
    @(negedge clk);
    smp_en = 0; trig_in = 0;
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = a; bus_wdat = d;
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = a;
    @(negedge clk);
    d = bus_rdat;
    chk(bus_ack === 1'b1 && bus_stall === 1'b0, "R8 ack/stall", {30'b0, bus_stall, bus_ack}, 32'h1);
    bus_cyc = 0; bus_stb = 0;
  endtask

  function automatic logic [31:0] exp_status();
    return {29'b0, hist.size() >= DEP, m_stop, m_hold};
  endfunction

  task automatic check_status(input string req);
    logic [31:0] s;
    bus_rd(0, s);
    chk(s === exp_status(), req, s, exp_status());
    chk(irq === m_stop, "R9 irq", {31'b0, irq}, {31'b0, m_stop});
  endtask

  task automatic check_readout(input string req);
    int n;
    logic [31:0] d;
    n = (hist.size() < DEP) ? hist.size() : DEP;
    for (int i = 0; i < n; i++) begin
      bus_rd(1, d);
      chk(d === hist[hist.size() - n + i], req, d, hist[hist.size() - n + i]);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check_status("R1 reset status");
    @(negedge clk);
    chk(bus_ack === 1'b0, "R8 no ack when idle", {31'b0, bus_ack}, 32'h0);

    // R3/R4/R5 table: wrap, held trigger, discard after stop
    for (int i = 0; i < 14; i++) begin
      sample(VEC[i][31:0], VEC[i][33], VEC[i][34]);
      chk(irq === VEC[i][32], "R4/R5 table irq", {31'b0, irq}, {31'b0, VEC[i][32]});
    end
    check_status("R6 status after wrap stop");

    // R2: ignored writes
    bus_wr(1, 32'hDEAD_BEEF);
    bus_wr(0, 32'h8000_0000);
    check_status("R2 ignored writes");
    // R7: oldest first after wrap; R3 keeps newest DEP
    check_readout("R7 wrapped readout");

    // R10: trigger/sample while stopped ignored, then re-arm
    sample(32'hF0, 1, 1);
    sample(32'hF1, 1, 0);
    bus_wr(0, 32'h0);
    model_reset();
    check_status("R10 clean re-arm");
    check_status("R1 bus reset");

    // R7 partial fill, R4 trigger on enabled sample
    sample(32'h11, 0, 1);
    sample(32'h22, 0, 0);
    sample(32'h33, 1, 1);
    check_status("R4 stop partial");
    check_readout("R7 partial readout");

    // R5 held trigger status
    bus_wr(0, 32'h7FFF_FFFF);
    model_reset();
    sample(32'h55, 1, 0);
    check_status("R5 held trigger");
    sample(32'h44, 0, 1);
    check_status("R5 stop on next sample");
    check_readout("R4 trigger sample newest");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule